// File: doc/BRIEF.md
# Load/Store Sub-Word Data Aligner

This block sits between a core's register file and a 32-bit, word-organized data memory. From a base register and a signed 16-bit displacement it forms the effective byte address, presents the word address to memory, and works out which of the four byte lanes a byte, halfword or word access touches. For stores it places the low 8, 16 or 32 bits of the source register on the selected lanes and raises a write strobe. For loads it picks the addressed lanes out of the returned memory word and widens them to 32 bits, either with the sign bit or with zeros.

The memory is assumed to return read data one clock after the request. On every clock edge the aligner therefore keeps the request's size, signedness and lane offset, and shapes the read word with that stored context during the following cycle. A halfword at an odd address, a word not on a 4-byte boundary, and the reserved size code all raise a misalignment flag. In those cases no lane is enabled and nothing is written. Exception handling is left to the surrounding pipeline.

Top module: `lsu_data_aligner`

## Requirements
- R1: The effective address is `base_i` plus `disp_i` sign-extended to 32 bits, modulo 2^32. `word_addr_o` carries bits 31:2 of that sum. A zero base gives absolute addressing and a zero displacement gives register-indirect addressing.
- R2: Size codes are 0 = byte, 1 = halfword, 2 = word and 3 = reserved. Lanes are little-endian: the byte at offset k of a word uses bits 8k+7:8k and `byte_en_o` bit k. An aligned byte enables exactly lane k, where k is address bits 1:0. An aligned halfword enables lanes 1:0 when address bit 1 is 0 and lanes 3:2 when it is 1. A word enables all four lanes.
- R3: `misalign_o` is 1 when any of the following holds: the size is halfword and address bit 0 is 1; the size is word and address bits 1:0 are not zero; the size code is 3. While it is 1, `byte_en_o` is 0000.
- R4: `wdata_o` holds the source low byte copied into all four lanes for a byte access. It holds the source low halfword copied into both halves for a halfword access, and the full source word for a word access.
- R5: `wr_en_o` is 1 exactly when `store_i` is 1 and `misalign_o` is 0.
- R6: In the cycle after a signed byte request, `ldata_o` is the byte of `mem_rdata_i` at the request's lane, sign-extended to 32 bits.
- R7: In the cycle after an unsigned byte or halfword request, `ldata_o` is the selected lane data zero-extended to 32 bits.
- R8: In the cycle after a halfword request, the selected halfword is `mem_rdata_i` bits 15:0 when address bit 1 was 0, and bits 31:16 when it was 1. A signed request sign-extends it.
- R9: In the cycle after a word request, `ldata_o` equals `mem_rdata_i`, whatever the signedness flag.
- R10: After reset, and until the first clock edge with reset released, the stored context is "word", so `ldata_o` equals `mem_rdata_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the load context is captured on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_i | input | 32 | Base register value |
| disp_i | input | 16 | Signed displacement |
| sdata_i | input | 32 | Store source register value |
| size_i | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 reserved |
| unsigned_i | input | 1 | 1 = zero-extend loaded data, 0 = sign-extend |
| store_i | input | 1 | 1 = store request, 0 = load request |
| mem_rdata_i | input | 32 | Memory read word, valid the cycle after the request |
| word_addr_o | output | 30 | Word address to memory |
| byte_en_o | output | 4 | Active byte lanes |
| wdata_o | output | 32 | Lane-steered store data |
| wr_en_o | output | 1 | Write strobe for the memory |
| ldata_o | output | 32 | Extended load result |
| misalign_o | output | 1 | Misaligned or reserved-size access |

## Verification
The assertions check on every clock the relations that hold whatever the operand values are. A misaligned access leaves every lane disabled. A byte access enables exactly one lane and an aligned halfword exactly two. The write strobe never appears without a store or during misalignment. A loaded byte fills the upper bits with its sign or with zeros, and a word load passes the read data through unchanged. The bench's scenarios are the only place where exact values are shown: lane position for every offset, the address sum with negative displacements and carry across bit 31, replicated store data, and which lane feeds the load result one cycle later.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int XLEN   = 32;
  localparam int LANES  = XLEN / 8;
  localparam int OFF_W  = $clog2(LANES);
  localparam int WADR_W = XLEN - OFF_W;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef struct packed {
    acc_size_e        size;
    logic             sgn;
    logic [OFF_W-1:0] off;
  } ld_ctx_t;

  // widen a signed displacement to the address width
  function automatic logic [XLEN-1:0] widen_disp(input logic [15:0] d);
    return {{(XLEN-16){d[15]}}, d};
  endfunction

  // misalignment rule for a size and the low address bits
  function automatic logic is_misaligned(input acc_size_e s, input logic [OFF_W-1:0] o);
    case (s)
      SZ_BYTE: return 1'b0;
      SZ_HALF: return o[0];
      SZ_WORD: return |o;
      default: return 1'b1;
    endcase
  endfunction

  // does lane l belong to an access of size s at offset o
  function automatic logic lane_hit(input acc_size_e s, input logic [OFF_W-1:0] o, input int l);
    case (s)
      SZ_BYTE: return (int'(o) == l);
      SZ_HALF: return (int'(o[OFF_W-1]) == (l / 2));
      SZ_WORD: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // byte that store data places on lane l
  function automatic logic [7:0] lane_wbyte(input acc_size_e s, input logic [XLEN-1:0] d, input int l);
    case (s)
      SZ_BYTE: return d[7:0];
      SZ_HALF: return d[8*(l%2) +: 8];
      default: return d[8*l +: 8];
    endcase
  endfunction
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_pkg::*;
#(
  parameter int DISP_W = 16
) (
  input  logic [XLEN-1:0]   base_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [XLEN-1:0]   ea_o
);
  logic [15:0] disp16;

  generate
    if (DISP_W >= 16) begin : g_trunc
      assign disp16 = disp_i[15:0];
    end else begin : g_ext
      assign disp16 = {{(16-DISP_W){disp_i[DISP_W-1]}}, disp_i};
    end
  endgenerate

  always_comb ea_o = base_i + widen_disp(disp16);
endmodule

// File: rtl/lsu_lane_steer.sv
module lsu_lane_steer
  import lsu_pkg::*;
(
  input  acc_size_e        size_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             store_i,
  input  logic [XLEN-1:0]  sdata_i,
  output logic [LANES-1:0] byte_en_o,
  output logic [XLEN-1:0]  wdata_o,
  output logic             wr_en_o,
  output logic             misalign_o
);
  logic bad;

  always_comb bad = is_misaligned(size_i, off_i);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      byte_en_o[l]       = lane_hit(size_i, off_i, l) & ~bad;
      wdata_o[8*l +: 8]  = lane_wbyte(size_i, sdata_i, l);
    end
  end

  always_comb begin
    misalign_o = bad;
    wr_en_o    = store_i & ~bad;
  end
endmodule

// File: rtl/lsu_load_extend.sv
module lsu_load_extend
  import lsu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  ld_ctx_t          ctx_d,
  input  logic [XLEN-1:0]  mem_rdata_i,
  output ld_ctx_t          ctx_q,
  output logic [XLEN-1:0]  ldata_o
);
  logic [7:0]  sel_b;
  logic [15:0] sel_h;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_q <= '{size: SZ_WORD, sgn: 1'b0, off: '0};
    end else begin
      ctx_q <= ctx_d;
    end
  end

  always_comb begin
    sel_b = mem_rdata_i[8*ctx_q.off +: 8];
    sel_h = ctx_q.off[OFF_W-1] ? mem_rdata_i[31:16] : mem_rdata_i[15:0];
    case (ctx_q.size)
      SZ_BYTE: ldata_o = {{(XLEN-8){ctx_q.sgn & sel_b[7]}}, sel_b};
      SZ_HALF: ldata_o = {{(XLEN-16){ctx_q.sgn & sel_h[15]}}, sel_h};
      default: ldata_o = mem_rdata_i;
    endcase
  end
endmodule

// File: rtl/lsu_data_aligner.sv
module lsu_data_aligner
  import lsu_pkg::*;
#(
  parameter int DISP_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [31:0]         base_i,
  input  logic [DISP_W-1:0]   disp_i,
  input  logic [31:0]         sdata_i,
  input  logic [1:0]          size_i,
  input  logic                unsigned_i,
  input  logic                store_i,
  input  logic [31:0]         mem_rdata_i,
  output logic [29:0]         word_addr_o,
  output logic [3:0]          byte_en_o,
  output logic [31:0]         wdata_o,
  output logic                wr_en_o,
  output logic [31:0]         ldata_o,
  output logic                misalign_o
);
  logic [XLEN-1:0] ea_w;
  acc_size_e       size_w;
  ld_ctx_t         ctx_next_w;
  ld_ctx_t         ctx_cur_w;
  // named context wires for the checker
  logic [1:0]      ctx_size_w;
  logic            ctx_signed_w;

  assign size_w = acc_size_e'(size_i);

  lsu_addr_gen #(.DISP_W(DISP_W)) u_agen (
    .base_i (base_i),
    .disp_i (disp_i),
    .ea_o   (ea_w)
  );

  lsu_lane_steer u_steer (
    .size_i     (size_w),
    .off_i      (ea_w[OFF_W-1:0]),
    .store_i    (store_i),
    .sdata_i    (sdata_i),
    .byte_en_o  (byte_en_o),
    .wdata_o    (wdata_o),
    .wr_en_o    (wr_en_o),
    .misalign_o (misalign_o)
  );

  always_comb begin
    ctx_next_w.size = size_w;
    ctx_next_w.sgn  = ~unsigned_i;
    ctx_next_w.off  = ea_w[OFF_W-1:0];
  end

  lsu_load_extend u_ext (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctx_d       (ctx_next_w),
    .mem_rdata_i (mem_rdata_i),
    .ctx_q       (ctx_cur_w),
    .ldata_o     (ldata_o)
  );

  assign word_addr_o  = ea_w[XLEN-1:OFF_W];
  assign ctx_size_w   = ctx_cur_w.size;
  assign ctx_signed_w = ctx_cur_w.sgn;
endmodule

// File: rtl/lsu_data_aligner_chk.sv
module lsu_data_aligner_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  size_i,
  input logic        store_i,
  input logic [31:0] mem_rdata_i,
  input logic [3:0]  byte_en_o,
  input logic        wr_en_o,
  input logic        misalign_o,
  input logic [31:0] ldata_o,
  input logic [1:0]  ctx_size_w,
  input logic        ctx_signed_w
);
  // R3
  misalign_no_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_o |-> (byte_en_o == 4'b0000));

  // R2
  byte_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (size_i == 2'd0) |-> ($countones(byte_en_o) == 1));

  // R2
  half_two_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((size_i == 2'd1) && !misalign_o) |-> ($countones(byte_en_o) == 2));

  // R5
  write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (store_i && !misalign_o));

  // R6
  byte_sign_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctx_size_w == 2'd0) && ctx_signed_w) |-> (ldata_o[31:8] == {24{ldata_o[7]}}));

  // R7
  byte_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctx_size_w == 2'd0) && !ctx_signed_w) |-> (ldata_o[31:8] == 24'h0));

  // R9
  word_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_size_w == 2'd2) |-> (ldata_o == mem_rdata_i));
endmodule

bind lsu_data_aligner lsu_data_aligner_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .size_i       (size_i),
  .store_i      (store_i),
  .mem_rdata_i  (mem_rdata_i),
  .byte_en_o    (byte_en_o),
  .wr_en_o      (wr_en_o),
  .misalign_o   (misalign_o),
  .ldata_o      (ldata_o),
  .ctx_size_w   (ctx_size_w),
  .ctx_signed_w (ctx_signed_w)
);

// File: tb/lsu_data_aligner_tb_top.sv
module lsu_data_aligner_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] base_i = '0;
  logic [15:0] disp_i = '0;
  logic [31:0] sdata_i = '0;
  logic [1:0]  size_i = 2'd2;
  logic        unsigned_i = 1'b0;
  logic        store_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic [29:0] word_addr_o;
  logic [3:0]  byte_en_o;
  logic [31:0] wdata_o;
  logic        wr_en_o;
  logic [31:0] ldata_o;
  logic        misalign_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // pending load contexts: {size, unsigned, offset}
  int q_size[$];
  int q_uns[$];
  int q_off[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lsu_data_aligner dut_i (
    .clk(clk), .rst_n(rst_n), .base_i(base_i), .disp_i(disp_i),
    .sdata_i(sdata_i), .size_i(size_i), .unsigned_i(unsigned_i),
    .store_i(store_i), .mem_rdata_i(mem_rdata_i), .word_addr_o(word_addr_o),
    .byte_en_o(byte_en_o), .wdata_o(wdata_o), .wr_en_o(wr_en_o),
    .ldata_o(ldata_o), .misalign_o(misalign_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference for one request plus the read word returned next cycle
  task automatic access(input logic [31:0] b, input logic [15:0] d, input logic [31:0] sd,
                        input int sz, input bit uns, input bit st, input logic [31:0] rd);
    longint ea;
    int off, mis, be, v, nb;
    logic [31:0] wexp, lexp;
    @(negedge clk);
    base_i = b; disp_i = d; sdata_i = sd; size_i = sz[1:0];
    unsigned_i = uns; store_i = st;
    ea = (longint'(b) + longint'($signed(d))) & 64'hFFFF_FFFF;
    off = int'(ea % 4);
    mis = (sz == 3) || (sz == 1 && (off % 2) == 1) || (sz == 2 && off != 0);
    nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    be = 0;
    if (!mis) for (int k = 0; k < nb; k++) be += 1 << (off - (off % nb) + k);
    wexp = '0;
    for (int k = 0; k < 4; k++) wexp[8*k +: 8] = sd[8*(k % nb) +: 8];
    #1;
    chk("R1 word address", {2'b0, word_addr_o}, 32'(ea / 4));
    chk("R2/R3 byte enables", {28'b0, byte_en_o}, 32'(be));
    chk("R3 misalign flag", {31'b0, misalign_o}, 32'(mis));
    chk("R5 write strobe", {31'b0, wr_en_o}, 32'(st && !mis));
    if (sz != 3) chk("R4 store data", wdata_o, wexp);
    q_size.push_back(sz); q_uns.push_back(int'(uns)); q_off.push_back(off);
    @(posedge clk);
    #1 mem_rdata_i = rd;
    #1;
    sz = q_size.pop_front(); off = q_off.pop_front(); v = q_uns.pop_front();
    if (sz == 0) begin
      lexp = (rd >> (8*off)) & 32'hFF;
      if (!v && lexp >= 128) lexp = lexp - 256;
      chk(v ? "R7 byte zero-extend" : "R6 byte sign-extend", ldata_o, lexp);
    end else if (sz == 1) begin
      lexp = (rd >> (8*(off / 2 * 2))) & 32'hFFFF;
      if (!v && lexp >= 32768) lexp = lexp - 65536;
      chk(v ? "R7/R8 half zero-extend" : "R8 half sign-extend", ldata_o, lexp);
    end else if (sz == 2) begin
      chk("R9 word pass", ldata_o, rd);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    mem_rdata_i = 32'h8765_43A1;
    repeat (3) @(posedge clk);
    #1;
    // R10 reset context is word
    chk("R10 reset pass-through", ldata_o, 32'h8765_43A1);
    @(negedge clk);
    rst_n = 1'b1;
    // every byte lane, signed and unsigned
    for (int o = 0; o < 4; o++) begin
      access(32'h0000_1000, 16'(o), 32'hDEAD_BEEF, 0, 0, 1, 32'h80F1_7F82);
      access(32'h0000_1000, 16'(o), 32'h0000_00C3, 0, 1, 0, 32'h80F1_7F82);
    end
    // halfwords at both aligned offsets and misaligned ones
    for (int o = 0; o < 4; o++) begin
      access(32'h0000_2000, 16'(o), 32'h1234_ABCD, 1, 0, 1, 32'h7FFE_8001);
      access(32'h0000_2000, 16'(o), 32'h1234_ABCD, 1, 1, 0, 32'h7FFE_8001);
    end
    // words, aligned and misaligned
    for (int o = 0; o < 4; o++)
      access(32'h0000_3000, 16'(o), 32'hCAFE_F00D, 2, o[0], 1, 32'hF00D_CAFE);
    // R1 negative displacement, absolute and register-indirect forms
    access(32'h0000_0010, 16'hFFF4, 32'h0, 2, 0, 0, 32'h1111_2222);
    access(32'h0000_0000, 16'h7FFC, 32'h55, 0, 0, 1, 32'h0000_0080);
    access(32'hFFFF_FFFE, 16'h0000, 32'h0, 1, 0, 0, 32'hFFFF_0000);
    access(32'hFFFF_FFF0, 16'h0013, 32'hA5, 0, 1, 0, 32'hAB00_0000);
    // R3 reserved size code
    access(32'h0000_4000, 16'h0, 32'h9, 3, 0, 1, 32'h0);
    // R9 word load ignores the signedness flag
    access(32'h0000_5000, 16'h8, 32'h0, 2, 1, 0, 32'h8000_0001);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule